// File: doc/BRIEF.md
# Grouped Pin Interrupt Summary with End-of-Interrupt Gating

This block gathers the pending state of many pins into a compact summary and drives one shared interrupt line toward the host. Pins are taken four at a time. One summary bit covers each group of four consecutive pins. A pin counts as pending when either its interrupt status or its wake status is high and its unmask enable is also high. The summary is registered once and presented as two 32-bit words. With the default 184 pins there are 46 groups. The low word carries groups 0 to 31 and the high word carries groups 32 to 45. The remaining high-word bits always read as zero.

The shared interrupt is level-like: it stays asserted while any group is pending. A handler scans the two words and services the pins. It then writes the master control register with the end-of-interrupt bit set. That write forces the shared line low for one cycle. The line then asserts again only if some group is still pending, so a source that arrived during servicing produces a fresh edge instead of being lost. The end-of-interrupt bit is a strobe and stores nothing.

Top module: `irq_group_agg`

## Requirements
- R1: Summary bit k is 1 when any pin in the range 4k to 4k+3 has its interrupt status input high while its unmask input is high.
- R2: A wake status input high on an unmasked pin sets its group's summary bit in the same way as interrupt status.
- R3: A pin whose unmask input is low does not affect the summary, whatever its status inputs.
- R4: `sum_lo_o` bit j holds group j for j from 0 to 31. `sum_hi_o` bit j holds group 32+j for j from 0 to 13. `sum_hi_o` bits 14 to 31 are always 0.
- R5: The summary outputs show the pin inputs sampled at the previous rising clock edge, which is one register stage.
- R6: `irq_o` asserts on the clock edge after the summary first becomes nonzero. It then stays high while the summary remains nonzero and no end-of-interrupt arrives.
- R7: Once the summary reads all zero, `irq_o` is low from the next clock edge.
- R8: A write with `ctrl_wr_i` high and `ctrl_eoi_i` high while `irq_o` is high drives `irq_o` low for exactly one cycle. `irq_o` then returns high if the summary is still nonzero.
- R9: If the summary is zero when the end-of-interrupt low cycle ends, `irq_o` stays low.
- R10: A master write with `ctrl_eoi_i` low has no effect on `irq_o`. An end-of-interrupt while `irq_o` is low also has no effect.
- R11: While `rst_n` is low, `irq_o` is 0 and both summary words are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_int_i | input | NUM_PINS | Per-pin interrupt status |
| pin_wake_i | input | NUM_PINS | Per-pin wake status |
| pin_unmask_i | input | NUM_PINS | Per-pin unmask enable (1 = may report) |
| ctrl_wr_i | input | 1 | Write strobe for the master control register |
| ctrl_eoi_i | input | 1 | End-of-interrupt bit of the write data |
| sum_lo_o | output | WORD_W | Summary groups 0 to 31 |
| sum_hi_o | output | WORD_W | Summary groups 32 to 45, upper bits zero |
| irq_o | output | 1 | Shared interrupt line |

## Verification
A wrong group reduction or a wrong word split shows up as a wrong bit in `sum_lo_o` or `sum_hi_o` one edge after the pin inputs change. Checking boundary groups such as 0, 31, 32 and 45 locates such a fault directly. A gating state stuck in its hold phase, or one that never leaves the asserted phase, shows at `irq_o` within two edges. That happens either when an end-of-interrupt is followed by a still-pending source, or when the summary drops to zero.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  typedef enum logic [1:0] {
    GATE_IDLE = 2'd0,
    GATE_LIVE = 2'd1,
    GATE_HOLD = 2'd2
  } gate_state_e;
endpackage

// File: rtl/irq_group_reduce.sv
module irq_group_reduce #(
  parameter int NUM_PINS   = 184,
  parameter int GROUP_SIZE = 4,
  localparam int NUM_GROUPS = (NUM_PINS + GROUP_SIZE - 1) / GROUP_SIZE,
  localparam int PAD_PINS   = NUM_GROUPS * GROUP_SIZE
) (
  input  logic [NUM_PINS-1:0]   pin_int_i,
  input  logic [NUM_PINS-1:0]   pin_wake_i,
  input  logic [NUM_PINS-1:0]   pin_unmask_i,
  output logic [NUM_GROUPS-1:0] grp_pend_o
);
  logic [PAD_PINS-1:0] live_pad;

  always_comb begin
    live_pad = '0;
    live_pad[NUM_PINS-1:0] = (pin_int_i | pin_wake_i) & pin_unmask_i;
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    assign grp_pend_o[g] = |live_pad[g*GROUP_SIZE +: GROUP_SIZE];
  end
endmodule

// File: rtl/irq_summary_reg.sv
module irq_summary_reg #(
  parameter int NUM_GROUPS = 46
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_GROUPS-1:0] grp_pend_i,
  output logic [NUM_GROUPS-1:0] sum_q_o,
  output logic                  any_q_o
);
  logic [NUM_GROUPS-1:0] sum_d;
  logic [NUM_GROUPS-1:0] sum_q;
  logic                  sum_en;

  always_comb begin
    sum_en = 1'b1;
    sum_d  = grp_pend_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
    end else if (sum_en) begin
      sum_q <= sum_d;
    end
  end

  assign sum_q_o = sum_q;
  assign any_q_o = |sum_q;
endmodule

// File: rtl/irq_eoi_gate.sv
module irq_eoi_gate
  import irq_agg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic any_pend_i,
  input  logic eoi_i,
  output logic irq_o
);
  gate_state_e state_q;
  gate_state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      GATE_IDLE: if (any_pend_i) state_d = GATE_LIVE;
      GATE_LIVE: begin
        if (eoi_i)            state_d = GATE_HOLD;
        else if (!any_pend_i) state_d = GATE_IDLE;
      end
      GATE_HOLD: state_d = any_pend_i ? GATE_LIVE : GATE_IDLE;
      default:   state_d = GATE_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GATE_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign irq_o = (state_q == GATE_LIVE);
endmodule

// File: rtl/irq_group_agg.sv
module irq_group_agg #(
  parameter int NUM_PINS   = 184,
  parameter int GROUP_SIZE = 4,
  parameter int WORD_W     = 32,
  localparam int NUM_GROUPS = (NUM_PINS + GROUP_SIZE - 1) / GROUP_SIZE,
  localparam int SUM_W      = 2 * WORD_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_int_i,
  input  logic [NUM_PINS-1:0] pin_wake_i,
  input  logic [NUM_PINS-1:0] pin_unmask_i,
  input  logic                ctrl_wr_i,
  input  logic                ctrl_eoi_i,
  output logic [WORD_W-1:0]   sum_lo_o,
  output logic [WORD_W-1:0]   sum_hi_o,
  output logic                irq_o
);
  logic [NUM_GROUPS-1:0] grp_pend;
  logic [NUM_GROUPS-1:0] sum_q;
  logic                  any_q;
  logic                  eoi_req;
  logic [SUM_W-1:0]      sum_pad;

  irq_group_reduce #(
    .NUM_PINS  (NUM_PINS),
    .GROUP_SIZE(GROUP_SIZE)
  ) u_reduce (
    .pin_int_i   (pin_int_i),
    .pin_wake_i  (pin_wake_i),
    .pin_unmask_i(pin_unmask_i),
    .grp_pend_o  (grp_pend)
  );

  irq_summary_reg #(
    .NUM_GROUPS(NUM_GROUPS)
  ) u_sum (
    .clk       (clk),
    .rst_n     (rst_n),
    .grp_pend_i(grp_pend),
    .sum_q_o   (sum_q),
    .any_q_o   (any_q)
  );

  assign eoi_req = ctrl_wr_i & ctrl_eoi_i;

  irq_eoi_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .any_pend_i(any_q),
    .eoi_i     (eoi_req),
    .irq_o     (irq_o)
  );

  always_comb begin
    sum_pad = '0;
    sum_pad[NUM_GROUPS-1:0] = sum_q;
  end

  assign sum_lo_o = sum_pad[WORD_W-1:0];
  assign sum_hi_o = sum_pad[SUM_W-1:WORD_W];
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
  parameter int NUM_PINS = 184,
  parameter int WORD_W   = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_PINS-1:0] pin_int_i,
  input logic [NUM_PINS-1:0] pin_wake_i,
  input logic [NUM_PINS-1:0] pin_unmask_i,
  input logic                ctrl_wr_i,
  input logic                ctrl_eoi_i,
  input logic [WORD_W-1:0]   sum_lo_o,
  input logic [WORD_W-1:0]   sum_hi_o,
  input logic                irq_o
);
  logic past_ok;
  logic any_live;
  logic sum_nz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  assign any_live = |((pin_int_i | pin_wake_i) & pin_unmask_i);
  assign sum_nz   = |{sum_hi_o, sum_lo_o};

  // R5: the summary follows the pin inputs one edge later
  a_r5_sum_follows: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (sum_nz == $past(any_live)));

  // R6: a rising interrupt needs a pending summary on the edge before
  a_r6_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $rose(irq_o)) |-> $past(sum_nz));

  // R7: an empty summary silences the line on the next edge
  a_r7_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !sum_nz |=> !irq_o);

  // R8: an end-of-interrupt during an active line forces a low cycle
  a_r8_eoi_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && ctrl_wr_i && ctrl_eoi_i) |=> !irq_o);

  // R10: a write without the end-of-interrupt bit keeps a pending line up
  a_r10_plain_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && sum_nz && !(ctrl_wr_i && ctrl_eoi_i)) |=> irq_o);
endmodule

bind irq_group_agg irq_agg_chk #(
  .NUM_PINS(NUM_PINS),
  .WORD_W  (WORD_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pin_int_i   (pin_int_i),
  .pin_wake_i  (pin_wake_i),
  .pin_unmask_i(pin_unmask_i),
  .ctrl_wr_i   (ctrl_wr_i),
  .ctrl_eoi_i  (ctrl_eoi_i),
  .sum_lo_o    (sum_lo_o),
  .sum_hi_o    (sum_hi_o),
  .irq_o       (irq_o)
);

// File: tb/irq_group_agg_tb_top.sv
`timescale 1ns/1ps
module irq_group_agg_tb_top;
  localparam int NP = 184;
  localparam int WW = 32;

  logic          clk;
  logic          rst_n;
  logic [NP-1:0] pin_int;
  logic [NP-1:0] pin_wake;
  logic [NP-1:0] pin_unmask;
  logic          ctrl_wr;
  logic          ctrl_eoi;
  logic [WW-1:0] sum_lo;
  logic [WW-1:0] sum_hi;
  logic          irq;

  int checks;
  int failures;
  bit done;

  irq_group_agg dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_int_i   (pin_int),
    .pin_wake_i  (pin_wake),
    .pin_unmask_i(pin_unmask),
    .ctrl_wr_i   (ctrl_wr),
    .ctrl_eoi_i  (ctrl_eoi),
    .sum_lo_o    (sum_lo),
    .sum_hi_o    (sum_hi),
    .irq_o       (irq)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [63:0] expect_sum(logic [NP-1:0] a, logic [NP-1:0] w,
                                             logic [NP-1:0] m);
    logic [63:0] r;
    r = '0;
    for (int p = 0; p < NP; p++)
      if ((a[p] | w[p]) & m[p]) r[p/4] = 1'b1;
    return r;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_sum(string tag);
    chk(tag, {sum_hi, sum_lo}, expect_sum(pin_int, pin_wake, pin_unmask));
  endtask

  task automatic clear_pins();
    pin_int  = '0;
    pin_wake = '0;
    step();
    step();
  endtask

  task automatic t_reset();
    chk("R11 irq in reset", {63'd0, irq}, 64'd0);
    chk("R11 summary in reset", {sum_hi, sum_lo}, 64'd0);
  endtask

  task automatic t_int_groups();
    pin_unmask = '1;
    pin_int = '0;
    pin_int[0] = 1'b1; pin_int[7] = 1'b1; pin_int[127] = 1'b1; pin_int[128] = 1'b1;
    step();
    chk_sum("R1 interrupt groups");
    chk("R4 low word groups 0,1,31", {32'd0, sum_lo}, 64'h0000_0000_8000_0003);
    chk("R4 high word group 32", {32'd0, sum_hi}, 64'h1);
    clear_pins();
  endtask

  task automatic t_wake();
    pin_wake[21] = 1'b1;
    step();
    chk_sum("R2 wake group 5");
    chk("R2 wake bit 5", {32'd0, sum_lo}, 64'h20);
    clear_pins();
  endtask

  task automatic t_mask();
    pin_unmask = '1;
    pin_unmask[9] = 1'b0;
    pin_int[9] = 1'b1;
    pin_wake[9] = 1'b1;
    step();
    chk("R3 masked pin ignored", {sum_hi, sum_lo}, 64'd0);
    step();
    chk("R3 masked pin no irq", {63'd0, irq}, 64'd0);
    pin_int[10] = 1'b1;
    step();
    chk("R3 unmasked neighbour", {32'd0, sum_lo}, 64'h4);
    pin_unmask = '1;
    clear_pins();
  endtask

  task automatic t_high_edge();
    pin_int[183] = 1'b1;
    pin_wake[180] = 1'b1;
    step();
    chk("R4 group 45 at high bit 13", {32'd0, sum_hi}, 64'h2000);
    chk_sum("R4 top group");
    clear_pins();
  endtask

  task automatic t_latency();
    pin_int[50] = 1'b1;
    #1;
    chk("R5 not yet visible", {sum_hi, sum_lo}, 64'd0);
    step();
    chk("R5 visible after one edge", {32'd0, sum_lo}, 64'h1000);
    clear_pins();
  endtask

  task automatic t_irq_level();
    pin_int[4] = 1'b1;
    step();
    chk("R6 irq waits one edge", {63'd0, irq}, 64'd0);
    step();
    chk("R6 irq asserted", {63'd0, irq}, 64'd1);
    step(); step();
    chk("R6 irq holds", {63'd0, irq}, 64'd1);
    pin_int[4] = 1'b0;
    step();
    chk("R7 irq still high while summary drains", {63'd0, irq}, 64'd1);
    step();
    chk("R7 irq low after empty summary", {63'd0, irq}, 64'd0);
  endtask

  task automatic t_eoi_rearm();
    pin_wake[100] = 1'b1;
    step(); step();
    chk("R8 irq high before eoi", {63'd0, irq}, 64'd1);
    ctrl_wr = 1'b1; ctrl_eoi = 1'b1;
    step();
    ctrl_wr = 1'b0; ctrl_eoi = 1'b0;
    chk("R8 low cycle after eoi", {63'd0, irq}, 64'd0);
    step();
    chk("R8 re-asserted while pending", {63'd0, irq}, 64'd1);
    clear_pins();
    chk("R8 cleanup", {63'd0, irq}, 64'd0);
  endtask

  task automatic t_eoi_drop();
    pin_int[60] = 1'b1;
    step(); step();
    chk("R9 irq high", {63'd0, irq}, 64'd1);
    pin_int[60] = 1'b0;
    ctrl_wr = 1'b1; ctrl_eoi = 1'b1;
    step();
    ctrl_wr = 1'b0; ctrl_eoi = 1'b0;
    chk("R9 low after eoi", {63'd0, irq}, 64'd0);
    step();
    chk("R9 stays low", {63'd0, irq}, 64'd0);
    step();
    chk("R9 still low", {63'd0, irq}, 64'd0);
  endtask

  task automatic t_eoi_noop();
    pin_int[2] = 1'b1;
    step(); step();
    ctrl_wr = 1'b1; ctrl_eoi = 1'b0;
    step();
    ctrl_wr = 1'b0;
    chk("R10 write without eoi bit", {63'd0, irq}, 64'd1);
    step();
    chk("R10 still high", {63'd0, irq}, 64'd1);
    clear_pins();
    ctrl_wr = 1'b1; ctrl_eoi = 1'b1;
    step();
    ctrl_wr = 1'b0; ctrl_eoi = 1'b0;
    chk("R10 idle eoi no effect", {63'd0, irq}, 64'd0);
    pin_int[2] = 1'b1;
    step(); step();
    chk("R10 normal assert after idle eoi", {63'd0, irq}, 64'd1);
    clear_pins();
  endtask

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    rst_n = 1'b0;
    pin_int = '0; pin_wake = '0; pin_unmask = '1;
    ctrl_wr = 1'b0; ctrl_eoi = 1'b0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    step();
    t_int_groups();
    t_wake();
    t_mask();
    t_high_edge();
    t_latency();
    t_irq_level();
    t_eoi_rearm();
    t_eoi_drop();
    t_eoi_noop();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule